// File: doc/BRIEF.md
# Leveled Interrupt Request Arbiter

This block holds one pending-request flag for each peripheral interrupt source and a two-bit urgency level for each source. Every clock it looks at every pending flag and picks one winner: the flag whose level has the smallest value. When several pending sources share that level, the one with the lowest index wins. It presents the result as a registered valid bit, the winning level and the winning source number. The processor side uses the source number to select a handler.

Peripherals set flags with single-cycle pulses. Software clears flags with a write port: every zero bit in the written word clears the matching flag, and every one bit leaves its flag alone. Accepting an interrupt never clears its flag. A source whose handler has already cleared its flag can raise it again while the handler is still running, and the arbiter then presents the new request. The number of sources is a parameter.

Top module: `lvl_irq_arbiter`

## Requirements
- R1: After reset all flags are 0, every source level is 3, and irq_valid, irq_level and irq_src are all 0.
- R2: A 1 on hw_set[i] at a clock edge sets flag i, and flags_q shows it after that edge. The flag then stays set, whatever the outputs show, until software clears it. A flag never becomes set without a hw_set pulse.
- R3: When flag_wr_en is 1, every bit of flag_wr_data that is 0 clears the matching flag at that edge. Bits that are 1 leave their flags unchanged. A flag never clears without such a write.
- R4: If hw_set[i] and a software clear of flag i happen at the same edge, flag i ends up set.
- R5: When lvl_wr_en is 1, the level of source lvl_wr_idx becomes lvl_wr_data. A write to an index of N or above changes no source.
- R6: irq_valid is registered. It is 1 exactly when at least one flag was set in the state captured at the previous edge.
- R7: irq_level is the smallest level value among the pending sources, so level 0 is the most urgent. irq_src names a pending source with that level.
- R8: When several pending sources share the winning level, irq_src is the lowest index among them.
- R9: When no flag is pending, irq_level and irq_src are 0.
- R10: A flag that is cleared and then set again by hardware is presented again as a request, one clock after it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_set | input | N | Per-source set pulses from the peripherals |
| flag_wr_en | input | 1 | Strobe for a software write to the flags |
| flag_wr_data | input | N | Write data; a 0 bit clears its flag |
| lvl_wr_en | input | 1 | Strobe for a level write |
| lvl_wr_idx | input | IDXW | Source whose level is written |
| lvl_wr_data | input | 2 | New level value; 0 is the most urgent |
| flags_q | output | N | Current flag register |
| irq_valid | output | 1 | Some request is pending |
| irq_level | output | 2 | Level of the winning request |
| irq_src | output | IDXW | Index of the winning source |

## Verification
The bench gives two pending sources the same level and checks that the lower index wins. A tree merged in the wrong direction would name the higher source instead. It sets and clears the same flag in one cycle, where a design that lets the clear win would drop a request. It writes ones through the flag port, which a design that treats the port as a plain store would lose. It writes a level to an index above the source count, which an index decoder that wraps around would apply to a real source. It clears a flag and sets it again, checks that an empty flag set gives all-zero outputs, and compares a behavioural model against the design on every clock during long random runs.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  typedef logic [1:0] irq_lvl_t;

  localparam irq_lvl_t LVL_LEAST = 2'd3;

  // a challenger only takes over when its level is strictly more urgent
  function automatic logic lvl_beats(input irq_lvl_t chal, input irq_lvl_t inc);
    return chal < inc;
  endfunction

  function automatic logic [63:0] flag_next(input logic [63:0] cur,
                                            input logic [63:0] set,
                                            input logic [63:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/lvl_irq_flags.sv
module lvl_irq_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] flags_q
);
  import lvl_irq_pkg::*;

  logic [N-1:0] clr_evt;
  logic [N-1:0] flags_d;
  logic [63:0]  nxt_wide;

  assign clr_evt  = wr_en ? ~wr_data : '0;
  assign nxt_wide = flag_next(64'(flags_q), 64'(hw_set), 64'(clr_evt));
  assign flags_d  = nxt_wide[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/lvl_irq_levels.sv
module lvl_irq_levels #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_data,
  output logic [2*N-1:0]  lvl_flat
);
  import lvl_irq_pkg::*;

  logic [N-1:0] wr_hit;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    irq_lvl_t lvl_q;
    assign wr_hit[i] = wr_en && (wr_idx == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lvl_q <= LVL_LEAST;
      else if (wr_hit[i]) lvl_q <= wr_data;
    end
    assign lvl_flat[2*i +: 2] = lvl_q;
  end
endmodule

// File: rtl/lvl_irq_pick.sv
module lvl_irq_pick #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    pend,
  input  logic [2*N-1:0]  lvl_flat,
  output logic            win_vld,
  output logic [1:0]      win_lvl,
  output logic [IDXW-1:0] win_idx
);
  import lvl_irq_pkg::*;

  localparam int LEAVES = 1 << $clog2(N);
  localparam int NODES  = 2 * LEAVES - 1;

  logic            nd_vld [NODES];
  irq_lvl_t        nd_lvl [NODES];
  logic [IDXW-1:0] nd_idx [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nd_vld[LEAVES-1+i] = pend[i];
      assign nd_lvl[LEAVES-1+i] = lvl_flat[2*i +: 2];
    end else begin : g_pad
      assign nd_vld[LEAVES-1+i] = 1'b0;
      assign nd_lvl[LEAVES-1+i] = LVL_LEAST;
    end
    assign nd_idx[LEAVES-1+i] = IDXW'(i);
  end

  // the left subtree always holds lower indices, so it keeps ties
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nd_vld[2*k+2] &&
                    (!nd_vld[2*k+1] || lvl_beats(nd_lvl[2*k+2], nd_lvl[2*k+1]));
    assign nd_vld[k] = nd_vld[2*k+1] | nd_vld[2*k+2];
    assign nd_lvl[k] = take_r ? nd_lvl[2*k+2] : nd_lvl[2*k+1];
    assign nd_idx[k] = take_r ? nd_idx[2*k+2] : nd_idx[2*k+1];
  end

  assign win_vld = nd_vld[0];
  assign win_lvl = nd_lvl[0];
  assign win_idx = nd_idx[0];
endmodule

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter #(
  parameter int N    = 8,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    hw_set,
  input  logic            flag_wr_en,
  input  logic [N-1:0]    flag_wr_data,
  input  logic            lvl_wr_en,
  input  logic [IDXW-1:0] lvl_wr_idx,
  input  logic [1:0]      lvl_wr_data,
  output logic [N-1:0]    flags_q,
  output logic            irq_valid,
  output logic [1:0]      irq_level,
  output logic [IDXW-1:0] irq_src
);
  logic [2*N-1:0]  lvl_flat;
  logic            win_vld;
  logic [1:0]      win_lvl;
  logic [IDXW-1:0] win_idx;

  lvl_irq_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
    .wr_en(flag_wr_en), .wr_data(flag_wr_data), .flags_q(flags_q)
  );

  lvl_irq_levels #(.N(N), .IDXW(IDXW)) u_levels (
    .clk(clk), .rst_n(rst_n), .wr_en(lvl_wr_en), .wr_idx(lvl_wr_idx),
    .wr_data(lvl_wr_data), .lvl_flat(lvl_flat)
  );

  lvl_irq_pick #(.N(N), .IDXW(IDXW)) u_pick (
    .pend(flags_q), .lvl_flat(lvl_flat),
    .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      irq_valid <= win_vld;
      irq_level <= win_vld ? win_lvl : 2'd0;
      irq_src   <= win_vld ? win_idx : '0;
    end
  end
endmodule

// File: rtl/lvl_irq_arbiter_chk.sv
module lvl_irq_arbiter_chk #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    hw_set,
  input logic            flag_wr_en,
  input logic [N-1:0]    flag_wr_data,
  input logic [N-1:0]    flags_q,
  input logic [2*N-1:0]  lvl_flat,
  input logic            irq_valid,
  input logic [1:0]      irq_level,
  input logic [IDXW-1:0] irq_src
);
  logic [N-1:0]   prev_flags;
  logic [2*N-1:0] prev_lvls;

  always_ff @(posedge clk) begin
    prev_flags <= flags_q;
    prev_lvls  <= lvl_flat;
  end

  // R6
  valid_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid == (|$past(flags_q)));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags_q & $past(hw_set)) == $past(hw_set)));

  // R2
  rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~$past(flags_q) & ~$past(hw_set)) == '0);

  // R3
  fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_q) & ~flags_q) != '0) |-> $past(flag_wr_en));

  // R7
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> prev_flags[irq_src]);

  // R7
  winner_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level == prev_lvls[2*irq_src +: 2]));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_level == 2'd0 && irq_src == '0));
endmodule

bind lvl_irq_arbiter lvl_irq_arbiter_chk #(.N(N), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .flag_wr_en(flag_wr_en),
  .flag_wr_data(flag_wr_data), .flags_q(flags_q), .lvl_flat(lvl_flat),
  .irq_valid(irq_valid), .irq_level(irq_level), .irq_src(irq_src)
);

// File: tb/lvl_irq_arbiter_tb.sv
`timescale 1ns/1ps
module lvl_irq_arbiter_tb;
  localparam int N    = 6;
  localparam int IDXW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    hw_set = '0;
  logic            flag_wr_en = 1'b0;
  logic [N-1:0]    flag_wr_data = '0;
  logic            lvl_wr_en = 1'b0;
  logic [IDXW-1:0] lvl_wr_idx = '0;
  logic [1:0]      lvl_wr_data = '0;
  logic [N-1:0]    flags_q;
  logic            irq_valid;
  logic [1:0]      irq_level;
  logic [IDXW-1:0] irq_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_flag [N];
  int m_lvl  [N];
  int e_vld, e_lvl, e_src;

  always #4 clk = ~clk;

  lvl_irq_arbiter #(.N(N), .IDXW(IDXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .flag_wr_en(flag_wr_en),
    .flag_wr_data(flag_wr_data), .lvl_wr_en(lvl_wr_en), .lvl_wr_idx(lvl_wr_idx),
    .lvl_wr_data(lvl_wr_data), .flags_q(flags_q), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_src(irq_src)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_flags();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_flag[i] != 0) v |= (1 << i);
    return v;
  endfunction

  // behavioural reference: outputs follow the state held before this edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_lvl[i] = 3; end
      e_vld = 0; e_lvl = 0; e_src = 0;
    end else begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++)
        if (m_flag[i] != 0 && (best < 0 || m_lvl[i] < m_lvl[best])) best = i;
      e_vld = (best >= 0) ? 1 : 0;
      e_lvl = (best >= 0) ? m_lvl[best] : 0;
      e_src = (best >= 0) ? best : 0;
      for (int i = 0; i < N; i++) begin
        if (flag_wr_en && !flag_wr_data[i]) m_flag[i] = 0;
        if (hw_set[i]) m_flag[i] = 1;
      end
      if (lvl_wr_en && int'(lvl_wr_idx) < N) m_lvl[lvl_wr_idx] = int'(lvl_wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq_valid vs model", int'(irq_valid), e_vld);
      check("R7 irq_level vs model", int'(irq_level), e_lvl);
      check("R8 irq_src vs model", int'(irq_src), e_src);
      check("R2 R3 R4 flags vs model", int'(flags_q), model_flags());
    end
  end

  task automatic drive(input logic [N-1:0] s, input logic fw, input logic [N-1:0] fd,
                       input logic lw, input int li, input int ld);
    @(negedge clk); #1;
    hw_set = s; flag_wr_en = fw; flag_wr_data = fd;
    lvl_wr_en = lw; lvl_wr_idx = IDXW'(li); lvl_wr_data = 2'(ld);
  endtask

  task automatic idle();
    drive('0, 1'b0, '0, 1'b0, 0, 0);
  endtask

  task automatic settle();
    idle(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset flags", int'(flags_q), 0);
    check("R1 reset valid", int'(irq_valid), 0);
    check("R1 reset level", int'(irq_level), 0);
    check("R1 reset src", int'(irq_src), 0);
    #1 rst_n = 1'b1;

    // R1 default level 3, R8 tie to lower index
    drive(6'b000110, 1'b0, '0, 1'b0, 0, 0);
    settle();
    check("R1 default level", int'(irq_level), 3);
    check("R8 tie lowest index", int'(irq_src), 1);

    // R7 more urgent level wins
    drive('0, 1'b0, '0, 1'b1, 4, 1);
    drive(6'b010000, 1'b0, '0, 1'b0, 0, 0);
    settle();
    check("R7 urgent src", int'(irq_src), 4);
    check("R7 urgent level", int'(irq_level), 1);

    // R8 tie at level 1 between sources 2 and 4
    drive('0, 1'b0, '0, 1'b1, 2, 1);
    settle();
    check("R8 tie src", int'(irq_src), 2);

    // R3 zero bit clears source 2
    drive('0, 1'b1, 6'b111011, 1'b0, 0, 0);
    settle();
    check("R3 clear flags", int'(flags_q), 'b010010);
    check("R3 winner after clear", int'(irq_src), 4);

    // R3 ones have no effect
    drive('0, 1'b1, 6'b111111, 1'b0, 0, 0);
    settle();
    check("R3 ones ignored", int'(flags_q), 'b010010);

    // R4 set wins over clear
    drive(6'b010000, 1'b1, 6'b101111, 1'b0, 0, 0);
    settle();
    check("R4 set beats clear", int'(flags_q), 'b010010);

    // R5 out-of-range level write ignored
    drive('0, 1'b0, '0, 1'b1, 6, 0);
    drive('0, 1'b0, '0, 1'b1, 7, 0);
    settle();
    check("R5 oob src", int'(irq_src), 4);
    check("R5 oob level", int'(irq_level), 1);

    // R10 handler clears then peripheral re-raises
    drive('0, 1'b1, 6'b101111, 1'b0, 0, 0);
    settle();
    check("R10 cleared src", int'(irq_src), 1);
    drive(6'b010000, 1'b0, '0, 1'b0, 0, 0);
    settle();
    check("R10 re-raised src", int'(irq_src), 4);

    // R9 empty gives zeros
    drive('0, 1'b1, '0, 1'b0, 0, 0);
    drive('0, 1'b0, '0, 1'b1, 5, 2);
    settle();
    check("R9 idle valid", int'(irq_valid), 0);
    check("R9 idle level", int'(irq_level), 0);
    check("R9 idle src", int'(irq_src), 0);

    // R2 flag persists
    drive(6'b100000, 1'b0, '0, 1'b0, 0, 0);
    repeat (10) idle();
    check("R2 persists valid", int'(irq_valid), 1);
    check("R2 persists src", int'(irq_src), 5);
    check("R2 persists level", int'(irq_level), 2);

    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      drive((r[2:0] == 0) ? N'($urandom) : '0,
            r[5:3] == 0, N'($urandom),
            r[8:6] == 0, int'(r[11:9]), int'(r[13:12]));
    end
    settle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule